// File: doc/BRIEF.md
# SPI Register Slave with One-Byte Reply Lag

This block is an SPI slave, mode 0, that lets an external master read and write a small bank of 8-bit control registers and read a bank of 8-bit status registers. Every transfer is built from whole bytes. A command byte names a register and whether it is read or written. A write command is followed by one data byte. The reply to a byte is placed in the transmit shift buffer only when the previous byte finishes. Because of this, what the master receives always trails its requests by one byte, and the first byte of a transfer repeats whatever was last loaded.

Register contents change only while chip select is inactive. Write data is held until chip select is released and is committed then. Status registers copy the live status inputs on every system clock while chip select is high and stay frozen while it is low. A sticky watchdog-expired flag sits in bit 7 of the first status register. The watchdog timer outside this block sets the flag, and a committed write that clears the watchdog-enable bit clears it.

The SPI pins are brought into the system clock domain through two-stage synchronisers. SCLK must therefore be slow compared with the system clock; a half period of at least eight system clocks works.

Top module: `spi_regbank`

## Requirements
- R1: After reset every control register is 00h, and the first byte shifted out on MISO is 00h.
- R2: Command byte: bit 7 = 1 means write and 0 means read, and bits 2:0 give the register address. Addresses 0-3 are control registers 0-3 and addresses 4-7 are status registers 0-3. Bytes are MSB first. MOSI is sampled on SCLK rising edges and MISO changes on falling edges. The addressed register's value is shifted out during the byte that follows the command.
- R3: During the data byte of a write, MISO carries the addressed register's contents from before the write.
- R4: Control registers (ctrl_o, register n in bits 8n+7:8n) do not change while chip select is low. A completed write takes effect only after chip select rises.
- R5: When a write is read back in a new transfer, the read command byte returns the old value and the following byte returns the new value.
- R6: Status register k is bits 8k+7:8k of {stat_i[30:7], wd_flag, stat_i[6:0]}, captured while chip select is high and held unchanged while it is low.
- R7: A write is discarded, leaving all registers unchanged, if chip select rises mid-byte, if the write command has no data byte, or if any further byte follows the data byte in the same transfer.
- R8: Bits 2:0 of control register 0 always read 0, whatever value is written.
- R9: A wd_trip_i pulse sets the watchdog flag (status register 0, bit 7). A committed write to control register 0 with bit 7 = 0 clears it, and a write with bit 7 = 1 leaves it set.
- R10: A write command to a status address (4-7) changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock from master |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| stat_i | input | NUM_STAT*8-1 | Live status inputs (bit 7 of status register 0 is the watchdog flag instead) |
| wd_trip_i | input | 1 | Watchdog expiry pulse, sets the sticky flag |
| ctrl_o | output | NUM_CTRL*8 | Control register contents, register n in bits 8n+7:8n |

## Verification
The hardest behaviour to reach from the ports is the one-byte lag, which stretches across chip-select frames. The old value of a register has to be seen twice: once during the write's data byte and once during the read command of a later frame, and only after that does the new value appear. The bench makes this happen by writing a value that differs from the reset value, then writing again and reading back in a new frame, so the stale and fresh bytes can be told apart. Frozen status is forced by changing stat_i right after chip select falls, and aborted writes are produced by raising chip select after four bits, after the command alone, and after an extra trailing byte.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int BIT_CW = $clog2(BYTE_W);
    localparam int WR_BIT = 7;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic              sclk_prev;
        logic              cs_prev;
        logic [BYTE_W-1:0] rx;
        logic [BIT_CW-1:0] bit_cnt;
        logic              byte_done;
        phase_e            phase;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
        logic              wr_ok;
        logic [BYTE_W-1:0] tx;
        logic              commit;
    } frame_t;

endpackage

// File: rtl/spi_regbank_sync.sv
module spi_regbank_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            sync_d[s] = sync_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {STAGES{RST_VAL}};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q[STAGES-1];

endmodule

// File: rtl/spi_regbank_frame.sv
module spi_regbank_frame
    import spi_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              miso_o,
    output logic              commit_o,
    output logic [ADDR_W-1:0] commit_addr_o,
    output logic [BYTE_W-1:0] commit_data_o
);

    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

    frame_t f_d, f_q;
    logic   sclk_rise, sclk_fall;
    logic [BYTE_W-1:0] rx_nxt;

    assign sclk_rise = sclk_s & ~f_q.sclk_prev;
    assign sclk_fall = ~sclk_s & f_q.sclk_prev;
    assign rx_nxt    = {f_q.rx[BYTE_W-2:0], mosi_s};

    always_comb begin
        f_d           = f_q;
        f_d.commit    = 1'b0;
        f_d.sclk_prev = sclk_s;
        f_d.cs_prev   = cs_n_s;
        if (cs_n_s) begin
            // Frame closed: a write survives only if its data byte ended the frame cleanly.
            if (!f_q.cs_prev) begin
                f_d.commit = f_q.wr_ok && (f_q.bit_cnt == '0);
            end
            f_d.bit_cnt   = '0;
            f_d.byte_done = 1'b0;
            f_d.phase     = PH_CMD;
            f_d.wr_ok     = 1'b0;
        end else if (sclk_rise) begin
            f_d.rx      = rx_nxt;
            f_d.bit_cnt = f_q.bit_cnt + 1'b1;
            if (f_q.bit_cnt == LAST_BIT) begin
                f_d.byte_done = 1'b1;
                f_d.wr_ok     = 1'b0;
                if (f_q.phase == PH_CMD) begin
                    f_d.addr  = rx_nxt[ADDR_W-1:0];
                    f_d.is_wr = rx_nxt[WR_BIT];
                    f_d.phase = rx_nxt[WR_BIT] ? PH_DATA : PH_CMD;
                end else begin
                    f_d.wdata = rx_nxt;
                    f_d.wr_ok = f_q.is_wr;
                    f_d.phase = PH_CMD;
                end
            end
        end else if (sclk_fall) begin
            if (f_q.byte_done) begin
                // Last falling edge of a byte: reload the reply buffer.
                f_d.tx        = rd_data_i;
                f_d.byte_done = 1'b0;
            end else begin
                f_d.tx = {f_q.tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q           <= '0;
            f_q.cs_prev   <= 1'b1;
            f_q.phase     <= PH_CMD;
        end else begin
            f_q <= f_d;
        end
    end

    assign rd_addr_o     = f_q.addr;
    assign miso_o        = f_q.tx[BYTE_W-1];
    assign commit_o      = f_q.commit;
    assign commit_addr_o = f_q.addr;
    assign commit_data_o = f_q.wdata;

endmodule

// File: rtl/spi_regbank_regs.sv
module spi_regbank_regs
    import spi_regbank_pkg::*;
#(
    parameter int NUM_CTRL = 4,
    parameter int NUM_STAT = 4,
    localparam int STAT_IN_W = NUM_STAT * BYTE_W - 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n_s,
    input  logic                       commit_i,
    input  logic [ADDR_W-1:0]          commit_addr_i,
    input  logic [BYTE_W-1:0]          commit_data_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    input  logic [STAT_IN_W-1:0]       stat_i,
    input  logic                       wd_trip_i,
    output logic [BYTE_W-1:0]          rd_data_o,
    output logic [NUM_CTRL*BYTE_W-1:0] ctrl_o,
    output logic [NUM_STAT*BYTE_W-1:0] stat_snap_o,
    output logic                       wd_flag_o
);

    localparam logic [BYTE_W-1:0] WD_CTRL_MASK = 8'hF8;
    localparam int                WDEN_BIT     = 7;

    typedef struct packed {
        logic [NUM_CTRL-1:0][BYTE_W-1:0] ctrl;
        logic [NUM_STAT-1:0][BYTE_W-1:0] stat;
        logic                            wd;
    } regs_t;

    regs_t r_d, r_q;
    logic [NUM_STAT-1:0][BYTE_W-1:0] live_stat;

    assign live_stat = {stat_i[STAT_IN_W-1:WDEN_BIT], r_q.wd, stat_i[WDEN_BIT-1:0]};

    always_comb begin
        r_d = r_q;
        if (wd_trip_i) begin
            r_d.wd = 1'b1;
        end
        if (commit_i) begin
            for (int i = 0; i < NUM_CTRL; i++) begin
                if (commit_addr_i == ADDR_W'(i)) begin
                    r_d.ctrl[i] = (i == 0) ? (commit_data_i & WD_CTRL_MASK) : commit_data_i;
                end
            end
            if (commit_addr_i == '0 && !commit_data_i[WDEN_BIT]) begin
                r_d.wd = 1'b0;
            end
        end
        if (cs_n_s) begin
            r_d.stat = live_stat;
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (rd_addr_i == ADDR_W'(i)) rd_data_o = r_q.ctrl[i];
        end
        for (int k = 0; k < NUM_STAT; k++) begin
            if (rd_addr_i == ADDR_W'(NUM_CTRL + k)) rd_data_o = r_q.stat[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctrl_o      = r_q.ctrl;
    assign stat_snap_o = r_q.stat;
    assign wd_flag_o   = r_q.wd;

endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
    import spi_regbank_pkg::*;
#(
    parameter int NUM_CTRL = 4,
    parameter int NUM_STAT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_sclk,
    input  logic                       spi_cs_n,
    input  logic                       spi_mosi,
    output logic                       spi_miso,
    input  logic [NUM_STAT*8-2:0]      stat_i,
    input  logic                       wd_trip_i,
    output logic [NUM_CTRL*8-1:0]      ctrl_o
);

    logic              sclk_s, cs_n_s, mosi_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [BYTE_W-1:0] rd_data;
    logic              commit;
    logic [ADDR_W-1:0] commit_addr;
    logic [BYTE_W-1:0] commit_data;
    logic [NUM_STAT*BYTE_W-1:0] stat_snap;
    logic              wd_flag;

    spi_regbank_sync #(
        .WIDTH  (3),
        .STAGES (2),
        .RST_VAL(3'b010)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({spi_sclk, spi_cs_n, spi_mosi}),
        .sync_o ({sclk_s, cs_n_s, mosi_s})
    );

    spi_regbank_frame u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_s       (sclk_s),
        .cs_n_s       (cs_n_s),
        .mosi_s       (mosi_s),
        .rd_data_i    (rd_data),
        .rd_addr_o    (rd_addr),
        .miso_o       (spi_miso),
        .commit_o     (commit),
        .commit_addr_o(commit_addr),
        .commit_data_o(commit_data)
    );

    spi_regbank_regs #(
        .NUM_CTRL(NUM_CTRL),
        .NUM_STAT(NUM_STAT)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_s       (cs_n_s),
        .commit_i     (commit),
        .commit_addr_i(commit_addr),
        .commit_data_i(commit_data),
        .rd_addr_i    (rd_addr),
        .stat_i       (stat_i),
        .wd_trip_i    (wd_trip_i),
        .rd_data_o    (rd_data),
        .ctrl_o       (ctrl_o),
        .stat_snap_o  (stat_snap),
        .wd_flag_o    (wd_flag)
    );

endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
    parameter int NUM_CTRL = 4,
    parameter int NUM_STAT = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_n_s,
    input logic                  spi_miso,
    input logic [NUM_CTRL*8-1:0] ctrl_o,
    input logic [NUM_STAT*8-1:0] stat_snap,
    input logic                  wd_flag,
    input logic                  commit,
    input logic [2:0]            commit_addr,
    input logic                  commit_wden,
    input logic                  wd_trip_i
);

    // R4: control registers hold while chip select stays low
    p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && !$past(cs_n_s)) |-> $stable(ctrl_o));

    // R4: a commit only ever happens with chip select released
    p_commit_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> cs_n_s);

    // R6: status snapshot frozen while chip select stays low
    p_stat_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_s && !$past(cs_n_s)) |-> $stable(stat_snap));

    // R8: low bits of control register 0 never set
    p_crwd_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[2:0] == 3'b000);

    // R2: MISO does not move while the slave is deselected
    p_miso_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s)) |-> $stable(spi_miso));

    // R9: enable-bit clear removes the watchdog flag
    p_wd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && commit_addr == 3'd0 && !commit_wden && !wd_trip_i) |=> !wd_flag);

    // R9: trip pulse sets the flag
    p_wd_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_trip_i && !commit) |=> wd_flag);

endmodule

bind spi_regbank spi_regbank_chk #(
    .NUM_CTRL(NUM_CTRL),
    .NUM_STAT(NUM_STAT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_s     (cs_n_s),
    .spi_miso   (spi_miso),
    .ctrl_o     (ctrl_o),
    .stat_snap  (stat_snap),
    .wd_flag    (wd_flag),
    .commit     (commit),
    .commit_addr(commit_addr),
    .commit_wden(commit_data[7]),
    .wd_trip_i  (wd_trip_i)
);

// File: tb/spi_regbank_bench.sv
module spi_regbank_bench;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        wd_trip = 1'b0;
    logic [30:0] stat_i = '0;
    logic        miso;
    logic [31:0] ctrl_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    spi_regbank u_spi_regbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sclk (sclk),
        .spi_cs_n (cs_n),
        .spi_mosi (mosi),
        .spi_miso (miso),
        .stat_i   (stat_i),
        .wd_trip_i(wd_trip),
        .ctrl_o   (ctrl_o)
    );

    function automatic logic [30:0] pack_stat(input logic [31:0] v);
        return {v[31:8], v[6:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [7:0] b, input int n, output logic [7:0] r);
        r = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = b[i];
            wait_clk(HALF);
            r[i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r);
        shift_bits(b, 8, r);
    endtask

    task automatic frame_open();
        cs_n = 1'b0;
        wait_clk(8);
    endtask

    task automatic frame_close();
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [7:0] d, output logic [7:0] during);
        logic [7:0] r;
        frame_open();
        xfer({5'b10000, a}, r);
        xfer(d, during);
        frame_close();
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [7:0] first, output logic [7:0] second);
        frame_open();
        xfer({5'b00000, a}, first);
        xfer(8'h00, second);
        frame_close();
    endtask

    task automatic t_reset();
        logic [7:0] f, s;
        chk("R1 ctrl after reset", ctrl_o, 32'h0);
        read_reg(3'd1, f, s);
        chk("R1 first byte after reset", f, 8'h00);
        chk("R2 read ctrl1 reset value", s, 8'h00);
    endtask

    task automatic t_write_commit();
        logic [7:0] r, d;
        frame_open();
        xfer(8'h81, r);
        xfer(8'hA5, d);
        wait_clk(20);
        chk("R4 ctrl held while cs low", ctrl_o, 32'h0);
        frame_close();
        chk("R3 old data during write byte", d, 8'h00);
        chk("R4 ctrl after cs rise", ctrl_o, 32'h0000_A500);
    endtask

    task automatic t_readback();
        logic [7:0] f, s, d;
        write_reg(3'd1, 8'h3C, d);
        chk("R3 old value during data byte", d, 8'hA5);
        read_reg(3'd1, f, s);
        chk("R5 read command returns old value", f, 8'hA5);
        chk("R5 next byte returns new value", s, 8'h3C);
    endtask

    task automatic t_status();
        logic [7:0] r, a, b;
        stat_i = pack_stat(32'h4433_2211);
        wait_clk(10);
        frame_open();
        stat_i = pack_stat(32'hAABB_CCDD);
        xfer(8'h05, r);
        xfer(8'h06, a);
        xfer(8'h00, b);
        frame_close();
        chk("R6 status1 frozen", a, 8'h22);
        chk("R6 status2 frozen", b, 8'h33);
        frame_open();
        xfer(8'h05, r);
        xfer(8'h00, a);
        frame_close();
        chk("R6 status1 refreshed", a, 8'hCC);
    endtask

    task automatic t_abort();
        logic [7:0] r;
        frame_open();
        xfer(8'h81, r);
        shift_bits(8'h77, 4, r);
        frame_close();
        chk("R7 partial data byte discarded", ctrl_o, 32'h0000_3C00);
        frame_open();
        xfer(8'h82, r);
        frame_close();
        chk("R7 write without data discarded", ctrl_o, 32'h0000_3C00);
        frame_open();
        xfer(8'h81, r);
        xfer(8'h77, r);
        xfer(8'h00, r);
        frame_close();
        chk("R7 trailing byte discards write", ctrl_o, 32'h0000_3C00);
    endtask

    task automatic t_crwd();
        logic [7:0] d, f, s;
        write_reg(3'd0, 8'hFF, d);
        chk("R8 ctrl0 low bits zero", ctrl_o, 32'h0000_3CF8);
        read_reg(3'd0, f, s);
        chk("R8 ctrl0 readback", s, 8'hF8);
    endtask

    task automatic t_watchdog();
        logic [7:0] d, f, s;
        stat_i = '0;
        @(negedge clk);
        wd_trip = 1'b1;
        @(negedge clk);
        wd_trip = 1'b0;
        wait_clk(6);
        read_reg(3'd4, f, s);
        chk("R9 flag set by trip", s, 8'h80);
        write_reg(3'd0, 8'hF8, d);
        read_reg(3'd4, f, s);
        chk("R9 flag kept with enable set", s, 8'h80);
        write_reg(3'd0, 8'h00, d);
        read_reg(3'd4, f, s);
        chk("R9 flag cleared with enable low", s, 8'h00);
        chk("R9 ctrl0 cleared", ctrl_o, 32'h0000_3C00);
    endtask

    task automatic t_status_write();
        logic [7:0] d, f, s;
        write_reg(3'd5, 8'hEE, d);
        chk("R10 write to status addr ignored ctrl", ctrl_o, 32'h0000_3C00);
        read_reg(3'd5, f, s);
        chk("R10 status1 unchanged", s, 8'h00);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write_commit();
        t_readback();
        t_status();
        t_abort();
        t_crwd();
        t_watchdog();
        t_status_write();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule